// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block sits between a processor with a 10-bit address bus and a 64 KB physical memory made of 128 banks of 512 bytes each. The processor address space is split in two halves. The lower half is a swappable window onto any bank. The upper half is a common area that always shows the last bank. The block turns every processor address into a 16-bit physical address, and it drives the chip select of either the ROM or the RAM.

The top address bit of the processor never reaches memory. It only picks the upper seven physical address bits. When it is 0, those bits come from a writable bank register. When it is 1, they are a constant 127. ROM or RAM is chosen from the bank number, not from the processor address. Banks 0 to 63 are ROM and banks 64 to 127 are RAM.

Inside the common area, eight processor addresses form an I/O window. An access there asserts one port select and no memory chip select. Port 0 of the window is the bank register itself. The rest of the common area holds scratch RAM ($200 to $3B7) and the stack ($3C0 to $3FF). The address is classified into one of four named regions: swap, scratch, io and stack. A one-cycle write path updates the bank register.

Top module: `bank_decoder_top`

## Requirements
- R1: When cpu_addr[9] is 0, phys_addr equals the bank register value times 512 plus cpu_addr[8:0].
- R2: When cpu_addr[9] is 1, phys_addr equals 127 times 512 plus cpu_addr[8:0], whatever the bank register holds.
- R3: After reset the bank register holds 0, so a block-0 read of address 0 gives phys_addr 0 with rom_cs asserted.
- R4: A write (cpu_wr=1) to address $3B8 loads cpu_wdata[6:0] into the bank register. Bit 7 is dropped. The new bank is used from the next clock cycle on.
- R5: On a read or a write outside the I/O window, rom_cs is 1 when the selected bank is 0 to 63, and ram_cs is 1 when it is 64 to 127. Never both are 1.
- R6: On a read or a write to addresses $3B8 to $3BF, io_sel bit (address minus $3B8) is the only bit set, and rom_cs, ram_cs and mem_we are 0.
- R7: mem_we is 1 only for a write that selects RAM. A write to a ROM bank gives mem_we 0.
- R8: With cpu_rd and cpu_wr both 0, io_sel, rom_cs, ram_cs and mem_we are all 0.
- R9: Writes to I/O ports 1 to 7 ($3B9 to $3BF) leave the bank register unchanged.
- R10: A read of port 0 ($3B8) leaves the bank register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 10 | Processor address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data, used for bank register loads |
| phys_addr | output | 16 | Physical memory address |
| rom_cs | output | 1 | ROM chip select |
| ram_cs | output | 1 | RAM chip select |
| mem_we | output | 1 | Memory write enable, RAM only |
| io_sel | output | 8 | One-hot I/O port select |

## Verification
Two functions meet across a cycle boundary. One is the bank register load. The other is the block-0 mapping that depends on the register. The bench provokes this by writing a new bank in one cycle and reading block 0 in the very next cycle. It expects the new bank in phys_addr in that second cycle, while block-1 reads in the same stretch must keep showing bank 127. The write cycle itself is judged too: io_sel bit 0 must be set and no chip select may be asserted while the register is being loaded.

// File: rtl/bdec_pkg.sv
package bdec_pkg;

    typedef enum logic [1:0] {
        RG_SWAP    = 2'd0,
        RG_SCRATCH = 2'd1,
        RG_IO      = 2'd2,
        RG_STACK   = 2'd3
    } region_e;

endpackage

// File: rtl/bdec_region.sv
module bdec_region
    import bdec_pkg::*;
#(
    parameter int CPU_AW     = 10,
    parameter int IO_BASE    = 'h3B8,
    parameter int IO_PORTS   = 8,
    parameter int STACK_BASE = 'h3C0
) (
    input  logic [CPU_AW-1:0]           addr,
    output region_e                     region,
    output logic [$clog2(IO_PORTS)-1:0] io_idx
);
    localparam int IDX_W = $clog2(IO_PORTS);
    localparam logic [CPU_AW-1:0] IO_LO = CPU_AW'(IO_BASE);
    localparam logic [CPU_AW-1:0] IO_HI = CPU_AW'(IO_BASE + IO_PORTS - 1);
    localparam logic [CPU_AW-1:0] ST_LO = CPU_AW'(STACK_BASE);

    logic [CPU_AW-1:0] io_off;

    always_comb begin
        io_off = addr - IO_LO;
        io_idx = io_off[IDX_W-1:0];
        if (!addr[CPU_AW-1]) begin
            region = RG_SWAP;
        end else if (addr >= IO_LO && addr <= IO_HI) begin
            region = RG_IO;
        end else if (addr >= ST_LO) begin
            region = RG_STACK;
        end else begin
            region = RG_SCRATCH;
        end
    end
endmodule

// File: rtl/bdec_bank_reg.sv
module bdec_bank_reg #(
    parameter int BANK_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output logic [BANK_W-1:0] bank_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (load) begin
            bank_q <= wdata[BANK_W-1:0];
        end
    end
endmodule

// File: rtl/bdec_map.sv
module bdec_map
    import bdec_pkg::*;
#(
    parameter int BANK_W   = 7,
    parameter int OFF_W    = 9,
    parameter int IO_PORTS = 8
) (
    input  region_e                     region,
    input  logic [$clog2(IO_PORTS)-1:0] io_idx,
    input  logic [OFF_W-1:0]            offset,
    input  logic [BANK_W-1:0]           bank_q,
    input  logic                        rd,
    input  logic                        wr,
    output logic [BANK_W+OFF_W-1:0]     phys_addr,
    output logic                        rom_cs,
    output logic                        ram_cs,
    output logic                        mem_we,
    output logic [IO_PORTS-1:0]         io_sel
);
    localparam logic [BANK_W-1:0] COMMON_BANK = '1;

    logic [BANK_W-1:0] bank_sel;
    logic              active;
    logic              mem_hit;
    logic              io_hit;
    logic              is_ram;

    always_comb begin
        active  = rd | wr;
        mem_hit = 1'b0;
        io_hit  = 1'b0;
        unique case (region)
            RG_SWAP: begin
                bank_sel = bank_q;
                mem_hit  = active;
            end
            RG_SCRATCH: begin
                bank_sel = COMMON_BANK;
                mem_hit  = active;
            end
            RG_STACK: begin
                bank_sel = COMMON_BANK;
                mem_hit  = active;
            end
            RG_IO: begin
                bank_sel = COMMON_BANK;
                io_hit   = active;
            end
            default: begin
                bank_sel = COMMON_BANK;
            end
        endcase
        is_ram    = bank_sel[BANK_W-1];
        phys_addr = {bank_sel, offset};
        rom_cs    = mem_hit & ~is_ram;
        ram_cs    = mem_hit &  is_ram;
        mem_we    = mem_hit &  is_ram & wr;
    end

    for (genvar k = 0; k < IO_PORTS; k++) begin : g_port
        assign io_sel[k] = io_hit && (io_idx == ($clog2(IO_PORTS))'(k));
    end
endmodule

// File: rtl/bank_decoder_top.sv
module bank_decoder_top
    import bdec_pkg::*;
#(
    parameter int CPU_AW     = 10,
    parameter int BANK_W     = 7,
    parameter int DATA_W     = 8,
    parameter int IO_BASE    = 'h3B8,
    parameter int IO_PORTS   = 8,
    parameter int STACK_BASE = 'h3C0,
    parameter int BANK_PORT  = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CPU_AW-1:0]          cpu_addr,
    input  logic                       cpu_rd,
    input  logic                       cpu_wr,
    input  logic [DATA_W-1:0]          cpu_wdata,
    output logic [BANK_W+CPU_AW-2:0]   phys_addr,
    output logic                       rom_cs,
    output logic                       ram_cs,
    output logic                       mem_we,
    output logic [IO_PORTS-1:0]        io_sel
);
    localparam int OFF_W = CPU_AW - 1;
    localparam int IDX_W = $clog2(IO_PORTS);

    region_e           region;
    logic [IDX_W-1:0]  io_idx;
    logic [BANK_W-1:0] bank_q;
    logic              bank_load;

    bdec_region #(
        .CPU_AW(CPU_AW), .IO_BASE(IO_BASE),
        .IO_PORTS(IO_PORTS), .STACK_BASE(STACK_BASE)
    ) region_i (
        .addr(cpu_addr), .region(region), .io_idx(io_idx)
    );

    assign bank_load = cpu_wr && (region == RG_IO) && (io_idx == IDX_W'(BANK_PORT));

    bdec_bank_reg #(.BANK_W(BANK_W), .DATA_W(DATA_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .load(bank_load),
        .wdata(cpu_wdata), .bank_q(bank_q)
    );

    bdec_map #(.BANK_W(BANK_W), .OFF_W(OFF_W), .IO_PORTS(IO_PORTS)) map_i (
        .region(region), .io_idx(io_idx), .offset(cpu_addr[OFF_W-1:0]),
        .bank_q(bank_q), .rd(cpu_rd), .wr(cpu_wr),
        .phys_addr(phys_addr), .rom_cs(rom_cs), .ram_cs(ram_cs),
        .mem_we(mem_we), .io_sel(io_sel)
    );
endmodule

// File: rtl/bdec_chk.sv
module bdec_chk #(
    parameter int CPU_AW   = 10,
    parameter int BANK_W   = 7,
    parameter int DATA_W   = 8,
    parameter int IO_BASE  = 'h3B8,
    parameter int IO_PORTS = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [CPU_AW-1:0]        cpu_addr,
    input logic                     cpu_rd,
    input logic                     cpu_wr,
    input logic [DATA_W-1:0]        cpu_wdata,
    input logic [BANK_W+CPU_AW-2:0] phys_addr,
    input logic                     rom_cs,
    input logic                     ram_cs,
    input logic                     mem_we,
    input logic [IO_PORTS-1:0]      io_sel
);
    localparam int PW = BANK_W + CPU_AW - 1;
    localparam logic [CPU_AW-1:0] PORT0 = CPU_AW'(IO_BASE);
    localparam logic [BANK_W-1:0] TOP_BANK = '1;

    p_common_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[CPU_AW-1] |-> phys_addr[PW-1:CPU_AW-1] == TOP_BANK);

    p_bank_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == PORT0) |=>
        (cpu_addr[CPU_AW-1] || phys_addr[PW-1:CPU_AW-1] == $past(cpu_wdata[BANK_W-1:0])));

    p_cs_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_cs && ram_cs));

    p_io_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(io_sel));

    p_io_no_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel != '0) |-> (!rom_cs && !ram_cs && !mem_we));

    p_rom_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs |-> !mem_we);

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd && !cpu_wr) |-> (io_sel == '0 && !rom_cs && !ram_cs && !mem_we));

    p_bank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!cpu_wr) && $past(!cpu_addr[CPU_AW-1]) && !cpu_addr[CPU_AW-1])
        |-> $stable(phys_addr[PW-1:CPU_AW-1]));
endmodule

bind bank_decoder_top bdec_chk #(
    .CPU_AW(CPU_AW), .BANK_W(BANK_W), .DATA_W(DATA_W),
    .IO_BASE(IO_BASE), .IO_PORTS(IO_PORTS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .phys_addr(phys_addr),
    .rom_cs(rom_cs), .ram_cs(ram_cs), .mem_we(mem_we), .io_sel(io_sel)
);

// File: tb/bank_decoder_top_tb_top.sv
module bank_decoder_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] cpu_addr = '0;
    logic       cpu_rd = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [15:0] phys_addr;
    logic        rom_cs, ram_cs, mem_we;
    logic [7:0]  io_sel;

    int checks = 0;
    int errors = 0;
    int model_bank = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_decoder_top dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .phys_addr(phys_addr),
        .rom_cs(rom_cs), .ram_cs(ram_cs), .mem_we(mem_we), .io_sel(io_sel)
    );

    task automatic access(input int a, input bit r, input bit w, input int d, input string req);
        int eb, ph;
        bit act, io, rom, ram, we;
        logic [7:0]  esel;
        logic [26:0] exp_v, act_v;
        @(negedge clk);
        cpu_addr  = 10'(a);
        cpu_rd    = r;
        cpu_wr    = w;
        cpu_wdata = 8'(d);
        #1;
        eb   = (a >= 512) ? 127 : model_bank;
        ph   = eb * 512 + (a % 512);
        act  = r | w;
        io   = (a >= 952) && (a <= 959);
        rom  = act && !io && (eb < 64);
        ram  = act && !io && (eb >= 64);
        we   = w && ram;
        esel = (act && io) ? 8'(1 << (a - 952)) : 8'h00;
        exp_v = {16'(ph), rom, ram, we, esel};
        act_v = {phys_addr, rom_cs, ram_cs, mem_we, io_sel};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s addr=%h rd=%0b wr=%0b: actual %h expected %h",
                     req, a, r, w, act_v, exp_v);
        end
        if (w && a == 952) model_bank = d % 128;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R3: reset bank is 0, ROM
        access(0, 1, 0, 0, "R3");
        access(511, 1, 0, 0, "R3");
        // R8: idle strobes
        for (int a = 0; a < 1024; a += 37) access(a, 0, 0, 8'hFF, "R8");
        access(952, 0, 0, 8'h55, "R8");
        // R1/R4/R5/R7: every bank, bit 7 set on odd banks
        for (int b = 0; b < 128; b++) begin
            access(952, 0, 1, (b % 2 == 1) ? b + 128 : b, "R4");
            access(b * 3 % 512, 1, 0, 0, "R4");
            for (int a = 0; a < 512; a += 8) access(a + (b % 8), 1, 0, 0, "R1");
            access(b % 512, 0, 1, 0, "R7");
            access(511 - b, 0, 1, 0, "R5");
            access(512 + b, 1, 0, 0, "R2");
            access(1023 - b, 0, 1, 0, "R2");
        end
        // R2/R6: full sweep of the common block with a RAM bank selected
        access(952, 0, 1, 77, "R4");
        for (int a = 512; a < 1024; a++) access(a, 1, 0, 0, "R2");
        for (int a = 952; a < 960; a++) access(a, 0, 1, 8'hA5, "R6");
        // R9: writes to other ports do not move the bank
        access(952, 0, 1, 12, "R4");
        for (int p = 1; p < 8; p++) begin
            access(952 + p, 0, 1, 100 + p, "R9");
            access(40, 1, 0, 0, "R9");
        end
        // R10: read of port 0 does not load
        access(952, 1, 0, 99, "R10");
        access(40, 1, 0, 0, "R10");
        access(952, 1, 1, 90, "R4");
        access(41, 0, 1, 0, "R7");
        done = 1'b1;
        finish_run();
    end
endmodule